// File: doc/BRIEF.md
# Three-Loop Supply and Clock Tuning Controller

This controller owns two codes for one die: a supply-voltage code in 1 mV units and a clock-frequency code in 10 MHz units. It sets them from three feedback loops. A speed loop raises the clock one step after every passing self-test on the functional pipeline and lowers it one step after a failure. A thermal loop takes voltage away while the die is hot. A budget loop moves the voltage up or down when a board-level power manager asks it to.

Work proceeds in evaluation periods. The controller pulses a test request. The self-test answers with a done strobe and a pass/fail bit. In the done cycle the controller applies at most one 1 mV voltage action and one frequency action. If the voltage moved, it waits a programmable settle time before it asks for the next test. Each loop has hysteresis. The thermal flag releases only below the hot limit minus a margin. After a failure the speed loop ignores a programmable number of passes before it probes upward again.

Top module: `dvfs_ctrl`

## Requirements
- R1: While reset is high the voltage code is 630, the frequency code is 40 and test_req_o is low. test_req_o is high in the first cycle after reset is released.
- R2: The voltage code never leaves the window 550 to 800. Repeated raise or lower actions stop at the limit.
- R3: After an evaluation the frequency code lies within fmin_i to fmax_i. A pass with no hold pending raises it by one.
- R4: A fail lowers the frequency code by one and loads a hold count of hold_evals_i. The next hold_evals_i passes leave the code unchanged, and the pass after them raises it.
- R5: When the thermal flag is set at an evaluation, the voltage drops by 1 whatever the power requests are. The flag sets when temp_i (degrees C, unsigned) is at least 125.
- R6: Once set, the thermal flag stays set until temp_i + therm_margin_i is below 125.
- R7: When neither thermal limiting nor pwr_dn_i applies, pwr_up_i raises the voltage by 1. pwr_dn_i lowers it by 1 and wins over pwr_up_i. At most one 1 mV action happens per evaluation.
- R8: If an evaluation changes the voltage, the next test_req_o pulse comes settle_cycles_i + 1 cycles after the cycle that follows the done cycle. Otherwise the pulse comes in the cycle right after the done cycle.
- R9: A done strobe that arrives during a settle interval is ignored. It changes neither code.
- R10: The codes change only in the cycle after an accepted done strobe. test_req_o is low in any cycle where the voltage code has just changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bist_done_i | input | 1 | Self-test result valid strobe |
| bist_pass_i | input | 1 | Self-test passed (valid with done) |
| temp_i | input | TW | Die temperature, degrees C |
| pwr_up_i | input | 1 | Budget loop asks for more voltage |
| pwr_dn_i | input | 1 | Budget loop asks for less voltage |
| therm_margin_i | input | TW | Thermal release margin, degrees C |
| hold_evals_i | input | CW | Passes to ignore after a fail |
| settle_cycles_i | input | CW | Settle delay after a voltage change |
| fmin_i | input | FW | Lowest allowed frequency code |
| fmax_i | input | FW | Highest allowed frequency code |
| vcode_o | output | VW | Voltage code, mV |
| fcode_o | output | FW | Frequency code, 10 MHz units |
| test_req_o | output | 1 | One-cycle request for a self-test |

## Verification
The thermal loop and the budget loop both want to act on the same evaluation. The bench holds a raise request while the temperature crosses the hot limit, sits inside the hysteresis band and then drops below the release point. The voltage must fall, fall again, and only then rise. A lower and a raise request are also held together, and the lower must win. A second done strobe is sent during the settle interval that a voltage move starts, and both codes must stay put. A behavioural model predicts every output in every cycle.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic {
        SEQ_WAIT   = 1'b0,
        SEQ_SETTLE = 1'b1
    } seq_state_e;

    // one fine step toward inc/dec (dec dominates), saturated to [lo, hi]
    function automatic logic [31:0] nudge(input logic [31:0] cur, input logic inc,
                                          input logic dec, input logic [31:0] lo,
                                          input logic [31:0] hi);
        logic [31:0] t;
        t = cur;
        if (dec)      t = (cur > lo) ? cur - 32'd1 : lo;
        else if (inc) t = cur + 32'd1;
        if (t > hi) t = hi;
        if (t < lo) t = lo;
        return t;
    endfunction

endpackage

// File: rtl/thermal_guard.sv
module thermal_guard #(
    parameter int unsigned TW  = 8,
    parameter int unsigned HOT = 125
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [TW-1:0] temp_i,
    input  logic [TW-1:0] margin_i,
    output logic          hot_o
);
    logic hot_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hot_q <= 1'b0;
        end else if (32'(temp_i) >= HOT) begin
            hot_q <= 1'b1;
        end else if (32'(temp_i) + 32'(margin_i) < HOT) begin
            hot_q <= 1'b0;
        end
    end

    assign hot_o = hot_q;
endmodule

// File: rtl/volt_arbiter.sv
module volt_arbiter
    import dvfs_pkg::*;
#(
    parameter int unsigned VW   = 10,
    parameter int unsigned VMIN = 550,
    parameter int unsigned VMAX = 800,
    parameter int unsigned VRST = 630
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          eval_i,
    input  logic          hot_i,
    input  logic          up_i,
    input  logic          dn_i,
    output logic [VW-1:0] vcode_o,
    output logic          moved_o
);
    logic [VW-1:0] v_q, v_n;
    logic          lower, raise;

    // thermal first, then budget decrease, then budget increase
    assign lower = hot_i | dn_i;
    assign raise = up_i & ~lower;

    always_comb begin
        v_n = v_q;
        if (eval_i) v_n = VW'(nudge(32'(v_q), raise, lower, VMIN, VMAX));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) v_q <= VW'(VRST);
        else       v_q <= v_n;
    end

    assign moved_o = (v_n != v_q);
    assign vcode_o = v_q;
endmodule

// File: rtl/freq_search.sv
module freq_search
    import dvfs_pkg::*;
#(
    parameter int unsigned FW   = 8,
    parameter int unsigned CW   = 8,
    parameter int unsigned FRST = 40
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          eval_i,
    input  logic          pass_i,
    input  logic [CW-1:0] hold_cfg_i,
    input  logic [FW-1:0] fmin_i,
    input  logic [FW-1:0] fmax_i,
    output logic [FW-1:0] fcode_o
);
    logic [FW-1:0] f_q, f_n;
    logic [CW-1:0] hold_q, hold_n;

    always_comb begin
        f_n    = f_q;
        hold_n = hold_q;
        if (eval_i) begin
            if (!pass_i) begin
                f_n    = FW'(nudge(32'(f_q), 1'b0, 1'b1, 32'(fmin_i), 32'(fmax_i)));
                hold_n = hold_cfg_i;
            end else if (hold_q != '0) begin
                f_n    = FW'(nudge(32'(f_q), 1'b0, 1'b0, 32'(fmin_i), 32'(fmax_i)));
                hold_n = hold_q - 1'b1;
            end else begin
                f_n    = FW'(nudge(32'(f_q), 1'b1, 1'b0, 32'(fmin_i), 32'(fmax_i)));
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            f_q    <= FW'(FRST);
            hold_q <= '0;
        end else begin
            f_q    <= f_n;
            hold_q <= hold_n;
        end
    end

    assign fcode_o = f_q;
endmodule

// File: rtl/eval_sequencer.sv
module eval_sequencer
    import dvfs_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          done_i,
    input  logic          moved_i,
    input  logic [CW-1:0] settle_i,
    output logic          eval_o,
    output logic          req_o
);
    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          req_q;

    assign eval_o = (state_q == SEQ_WAIT) && done_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_SETTLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            case (state_q)
                SEQ_SETTLE: begin
                    if (cnt_q == '0) begin
                        req_q   <= 1'b1;
                        state_q <= SEQ_WAIT;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (done_i) begin
                        if (moved_i) begin
                            state_q <= SEQ_SETTLE;
                            cnt_q   <= settle_i;
                        end else begin
                            req_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
    import dvfs_pkg::*;
#(
    parameter int unsigned VW   = 10,
    parameter int unsigned FW   = 8,
    parameter int unsigned TW   = 8,
    parameter int unsigned CW   = 8,
    parameter int unsigned VMIN = 550,
    parameter int unsigned VMAX = 800,
    parameter int unsigned VRST = 630,
    parameter int unsigned FRST = 40,
    parameter int unsigned HOT  = 125
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          bist_done_i,
    input  logic          bist_pass_i,
    input  logic [TW-1:0] temp_i,
    input  logic          pwr_up_i,
    input  logic          pwr_dn_i,
    input  logic [TW-1:0] therm_margin_i,
    input  logic [CW-1:0] hold_evals_i,
    input  logic [CW-1:0] settle_cycles_i,
    input  logic [FW-1:0] fmin_i,
    input  logic [FW-1:0] fmax_i,
    output logic [VW-1:0] vcode_o,
    output logic [FW-1:0] fcode_o,
    output logic          test_req_o
);
    logic eval_w, hot_w, moved_w;

    thermal_guard #(.TW(TW), .HOT(HOT)) u_therm (
        .clk_i(clk_i), .rst_i(rst_i), .temp_i(temp_i),
        .margin_i(therm_margin_i), .hot_o(hot_w)
    );

    volt_arbiter #(.VW(VW), .VMIN(VMIN), .VMAX(VMAX), .VRST(VRST)) u_volt (
        .clk_i(clk_i), .rst_i(rst_i), .eval_i(eval_w), .hot_i(hot_w),
        .up_i(pwr_up_i), .dn_i(pwr_dn_i), .vcode_o(vcode_o), .moved_o(moved_w)
    );

    freq_search #(.FW(FW), .CW(CW), .FRST(FRST)) u_freq (
        .clk_i(clk_i), .rst_i(rst_i), .eval_i(eval_w), .pass_i(bist_pass_i),
        .hold_cfg_i(hold_evals_i), .fmin_i(fmin_i), .fmax_i(fmax_i),
        .fcode_o(fcode_o)
    );

    eval_sequencer #(.CW(CW)) u_seq (
        .clk_i(clk_i), .rst_i(rst_i), .done_i(bist_done_i), .moved_i(moved_w),
        .settle_i(settle_cycles_i), .eval_o(eval_w), .req_o(test_req_o)
    );
endmodule

// File: rtl/dvfs_ctrl_chk.sv
module dvfs_ctrl_chk #(
    parameter int unsigned VW   = 10,
    parameter int unsigned FW   = 8,
    parameter int unsigned VMIN = 550,
    parameter int unsigned VMAX = 800
) (
    input logic          clk,
    input logic          rst,
    input logic          eval,
    input logic          hot,
    input logic          test_req,
    input logic [VW-1:0] vcode,
    input logic [FW-1:0] fcode
);
    // R2
    v_window_chk: assert property (@(posedge clk) disable iff (rst)
        32'(vcode) >= VMIN && 32'(vcode) <= VMAX);

    // R7
    v_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        32'(vcode) == 32'($past(vcode)) || 32'(vcode) == 32'($past(vcode)) + 32'd1 ||
        32'(vcode) + 32'd1 == 32'($past(vcode)));

    // R10
    v_cause_chk: assert property (@(posedge clk) disable iff (rst)
        vcode != $past(vcode) |-> $past(eval));

    // R10
    f_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fcode != $past(fcode) |-> $past(eval));

    // R8
    quiet_after_move_chk: assert property (@(posedge clk) disable iff (rst)
        vcode != $past(vcode) |-> !test_req);

    // R5
    hot_lowers_chk: assert property (@(posedge clk) disable iff (rst)
        eval && hot |=> 32'(vcode) + 32'd1 == 32'($past(vcode)) || 32'($past(vcode)) == VMIN);
endmodule

bind dvfs_ctrl dvfs_ctrl_chk #(.VW(VW), .FW(FW), .VMIN(VMIN), .VMAX(VMAX)) u_chk (
    .clk(clk_i), .rst(rst_i), .eval(eval_w), .hot(hot_w),
    .test_req(test_req_o), .vcode(vcode_o), .fcode(fcode_o)
);

// File: tb/dvfs_ctrl_test.sv
`timescale 1ns/1ps
module dvfs_ctrl_test;
    localparam int SETTLE = 4, HOLD = 3, MARGIN = 5, FMIN = 20, FMAX = 45;

    logic       clk = 1'b0, rst_i = 1'b1;
    logic       bist_done_i = 1'b0, bist_pass_i = 1'b0;
    logic [7:0] temp_i = 8'd60;
    logic       pwr_up_i = 1'b0, pwr_dn_i = 1'b0;
    logic [9:0] vcode_o;
    logic [7:0] fcode_o;
    logic       test_req_o;

    int n_cmp = 0, n_bad = 0, cycles = 0, gap;
    bit started = 1'b0;

    dvfs_ctrl uut (
        .clk_i(clk), .rst_i(rst_i), .bist_done_i(bist_done_i), .bist_pass_i(bist_pass_i),
        .temp_i(temp_i), .pwr_up_i(pwr_up_i), .pwr_dn_i(pwr_dn_i),
        .therm_margin_i(8'(MARGIN)), .hold_evals_i(8'(HOLD)), .settle_cycles_i(8'(SETTLE)),
        .fmin_i(8'(FMIN)), .fmax_i(8'(FMAX)),
        .vcode_o(vcode_o), .fcode_o(fcode_o), .test_req_o(test_req_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // behavioural reference model
    int  m_v, m_f, m_hold, m_cnt, nv;
    bit  m_hot, m_settling, m_req, was_hot;

    always @(posedge clk) begin
        cycles++;
        started = 1'b1;
        if (rst_i) begin
            m_v = 630; m_f = 40; m_hold = 0; m_hot = 0;
            m_settling = 1; m_cnt = 0; m_req = 0;
        end else begin
            was_hot = m_hot;
            if (int'(temp_i) >= 125) m_hot = 1;
            else if (int'(temp_i) + MARGIN < 125) m_hot = 0;
            m_req = 0;
            if (m_settling) begin
                if (m_cnt == 0) begin m_req = 1; m_settling = 0; end
                else m_cnt--;
            end else if (bist_done_i) begin
                nv = m_v;
                if (was_hot || pwr_dn_i) nv = (m_v > 550) ? m_v - 1 : 550;
                else if (pwr_up_i) nv = (m_v < 800) ? m_v + 1 : 800;
                if (!bist_pass_i) begin m_f--; m_hold = HOLD; end
                else if (m_hold > 0) m_hold--;
                else m_f++;
                if (m_f < FMIN) m_f = FMIN;
                if (m_f > FMAX) m_f = FMAX;
                if (nv != m_v) begin m_v = nv; m_settling = 1; m_cnt = SETTLE; end
                else m_req = 1;
            end
        end
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R2 vcode vs model", int'(vcode_o), m_v);
            chk("R3 fcode vs model", int'(fcode_o), m_f);
            chk("R8 test_req vs model", int'(test_req_o), int'(m_req));
        end
    end

    task automatic run(input bit pass, output int g);
        while (!test_req_o) @(negedge clk);
        @(negedge clk);
        bist_done_i = 1'b1; bist_pass_i = pass;
        @(negedge clk);
        bist_done_i = 1'b0;
        g = 0;
        while (!test_req_o) begin @(negedge clk); g++; end
    endtask

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        chk("R1 reset vcode", int'(vcode_o), 630);
        chk("R1 reset fcode", int'(fcode_o), 40);
        chk("R1 reset req", int'(test_req_o), 0);
        rst_i = 1'b0;
        @(negedge clk);
        chk("R1 first req", int'(test_req_o), 1);

        // R3: climb to the upper clamp, no voltage motion so no settle gap
        for (int i = 0; i < 7; i++) begin
            run(1'b1, gap);
            chk("R8 gap without move", gap, 0);
        end
        chk("R3 fmax clamp", int'(fcode_o), FMAX);

        // R4: fail then hold
        run(1'b0, gap);
        chk("R4 fail steps down", int'(fcode_o), FMAX - 1);
        for (int i = 0; i < HOLD; i++) run(1'b1, gap);
        chk("R4 held during hold", int'(fcode_o), FMAX - 1);
        run(1'b1, gap);
        chk("R4 probe after hold", int'(fcode_o), FMAX);

        // R7/R8: raise request with settle gap
        pwr_up_i = 1'b1;
        run(1'b1, gap);
        chk("R7 raise by one", int'(vcode_o), 631);
        chk("R8 settle gap", gap, SETTLE + 1);

        // R9: done during settle is ignored
        @(negedge clk);
        bist_done_i = 1'b1; bist_pass_i = 1'b1;
        @(negedge clk);
        bist_done_i = 1'b1; bist_pass_i = 1'b0;
        @(negedge clk);
        bist_done_i = 1'b0;
        while (!test_req_o) @(negedge clk);
        chk("R9 vcode after ignored done", int'(vcode_o), 632);
        chk("R9 fcode after ignored done", int'(fcode_o), FMAX);

        // R7: lower wins over raise
        pwr_dn_i = 1'b1;
        run(1'b1, gap);
        chk("R7 lower wins", int'(vcode_o), 631);
        pwr_dn_i = 1'b0;

        // R5/R6: thermal limit against a raise request
        temp_i = 8'd125;
        run(1'b1, gap);
        chk("R5 hot lowers", int'(vcode_o), 630);
        temp_i = 8'd122;
        run(1'b1, gap);
        chk("R6 inside band still hot", int'(vcode_o), 629);
        temp_i = 8'd119;
        run(1'b1, gap);
        chk("R6 released raises", int'(vcode_o), 630);
        temp_i = 8'd60;

        // R2: upper and lower voltage limits
        for (int i = 0; i < 180; i++) run(1'b1, gap);
        chk("R2 vmax clamp", int'(vcode_o), 800);
        v0 = int'(vcode_o);
        run(1'b1, gap);
        chk("R2 no move at vmax gap", gap, 0);
        pwr_up_i = 1'b0; pwr_dn_i = 1'b1;
        for (int i = 0; i < 260; i++) run(1'b1, gap);
        chk("R2 vmin clamp", int'(vcode_o), 550);
        pwr_dn_i = 1'b0;

        // R3: lower frequency limit
        for (int i = 0; i < 30; i++) run(1'b0, gap);
        chk("R3 fmin clamp", int'(fcode_o), FMIN);
        chk("R10 vcode steady without requests", int'(vcode_o), 550);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule